// File: doc/BRIEF.md
# UART Channel Doze Controller

This block decides when one UART channel may stop its oscillator and when it must start it again. Software arms the feature with two enable bits. The first bit lives in an extended register that can only be reached while the line-format register holds a key value. The second bit lives in the interrupt-enable register, and it can only be written once the first bit is set.

Once both bits are set, the controller puts the channel to sleep when all of these hold: no interrupt is pending, neither the transmitter nor the receiver is busy, and no wake event is in progress. Three kinds of event wake the channel: a falling edge on the receive line (a start bit), any edge on one of the sampled modem status inputs, and a write into the transmit FIFO. When the work caused by a wake-up has drained, the channel goes back to sleep on its own. This repeats until software clears the interrupt-enable bit. The configuration registers keep their contents while the channel sleeps.

Top module: `uart_doze_ctrl`

## Requirements
- R1: After reset all three configuration registers read 0x00, `asleep` is 0 and `osc_en` is 1.
- R2: Address 2 reaches the extended register only while the line-format register (address 3) holds the key 0xBF. At any other time, writes to address 2 are dropped and reads of it return 0x00.
- R3: Bit 4 of the interrupt-enable register (address 1) takes a written value only while bit 4 of the extended register is 1. The other interrupt-enable bits always take the written value.
- R4: Sleep needs bit 4 set in both the extended register and the interrupt-enable register. With both set and the channel idle, `asleep` rises at the next clock edge, and from then on `osc_en` is 0.
- R5: While `irq_pend` is 1, `osc_en` is 1 in the same cycle and the channel does not enter sleep.
- R6: A 1-to-0 transition of `rx_line` between two samples raises `osc_en` at once and clears `asleep` at the next edge. A line that stays low does not wake the channel again.
- R7: Any change of any `modem_n` bit between two samples wakes the channel in the same way as R6.
- R8: A `txf_wr` pulse wakes the channel in the same way as R6.
- R9: While `tx_busy` or `rx_busy` is 1, the channel does not sleep. One cycle after both are 0 again, it returns to sleep with no software action.
- R10: Clearing interrupt-enable bit 4 raises `osc_en` in the cycle after the write and keeps the channel awake from then on, whatever wake events follow.
- R11: Register contents do not change while the channel sleeps, and register reads do not wake it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (1 int-enable, 2 extended, 3 line-format) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr`, combinational |
| irq_pend | input | 1 | An interrupt of the channel is pending |
| rx_line | input | 1 | Serial receive line, idle high |
| modem_n | input | 4 | Modem status inputs, active low |
| txf_wr | input | 1 | Write strobe into the transmit FIFO |
| tx_busy | input | 1 | Transmitter still holds data |
| rx_busy | input | 1 | Receiver still holds unread data |
| osc_en | output | 1 | Oscillator enable |
| asleep | output | 1 | Channel is in the sleep state |

## Verification
The bench builds the block with its default parameters: 8-bit registers, four modem inputs, key 0xBF and enable bit 4. With these values, every path through the key gate and the write mask of the enable bit can be exercised with a few writes. The four modem inputs are few enough to toggle one line down and back up, and so to show that edges in both directions wake the channel. Because the expected cycle of every sleep entry and exit is written out step by step, a one-cycle slip in the wake or re-entry path shows up as a mismatch.

// File: rtl/doze_pkg.sv
package doze_pkg;

  typedef enum logic [1:0] {
    ADR_NONE = 2'd0,
    ADR_IEN  = 2'd1,
    ADR_EXT  = 2'd2,
    ADR_FMT  = 2'd3
  } doze_addr_e;

  // Falling edge between two samples of a line that idles high.
  function automatic logic start_seen(input logic prev, input logic now);
    return prev & ~now;
  endfunction

  // Merge a written byte with the old one: bits under mask are kept unless open.
  function automatic logic [7:0] guarded_merge(input logic [7:0] old_v,
                                               input logic [7:0] new_v,
                                               input logic [7:0] mask,
                                               input logic       open);
    return (new_v & ~mask) | ((open ? new_v : old_v) & mask);
  endfunction

endpackage

// File: rtl/doze_regs.sv
module doze_regs
  import doze_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter logic [7:0]  KEY  = 8'hBF,
  parameter int unsigned SBIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] fmt_q,
  output logic [DW-1:0] ien_q,
  output logic [DW-1:0] ext_q,
  output logic          sleep_ok,
  output logic          key_open
);
  localparam logic [7:0] SMASK = 8'(1 << SBIT);

  assign key_open = (fmt_q == KEY);
  assign sleep_ok = ext_q[SBIT] & ien_q[SBIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0;
      ien_q <= '0;
      ext_q <= '0;
    end else if (wr) begin
      case (doze_addr_e'(addr))
        ADR_IEN: ien_q <= guarded_merge(ien_q, wdata, SMASK, ext_q[SBIT]);
        ADR_EXT: if (key_open) ext_q <= wdata;
        ADR_FMT: fmt_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (doze_addr_e'(addr))
      ADR_IEN: rdata = ien_q;
      ADR_EXT: rdata = key_open ? ext_q : '0;
      ADR_FMT: rdata = fmt_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/doze_activity.sv
module doze_activity
  import doze_pkg::*;
#(
  parameter int unsigned MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic [MW-1:0] modem_n,
  input  logic          txf_wr,
  output logic          rx_start,
  output logic          modem_chg,
  output logic          wake_evt
);
  logic          rx_q;
  logic [MW-1:0] mod_q;
  logic [MW-1:0] mod_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 1'b1;
      mod_q <= '1;
    end else begin
      rx_q  <= rx_line;
      mod_q <= modem_n;
    end
  end

  for (genvar i = 0; i < MW; i++) begin : g_edge
    assign mod_edge[i] = mod_q[i] ^ modem_n[i];
  end

  assign rx_start  = start_seen(rx_q, rx_line);
  assign modem_chg = |mod_edge;
  assign wake_evt  = rx_start | modem_chg | txf_wr;
endmodule

// File: rtl/doze_fsm.sv
module doze_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_ok,
  input  logic irq_pend,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic wake_evt,
  output logic idle_ok,
  output logic asleep,
  output logic osc_en
);
  assign idle_ok = sleep_ok & ~irq_pend & ~tx_busy & ~rx_busy & ~wake_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) asleep <= 1'b0;
    else        asleep <= idle_ok;
  end

  assign osc_en = ~asleep | wake_evt | irq_pend | ~sleep_ok;
endmodule

// File: rtl/uart_doze_ctrl.sv
module uart_doze_ctrl #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MODEM_W = 4,
  parameter logic [7:0]  KEY     = 8'hBF,
  parameter int unsigned SBIT    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic               irq_pend,
  input  logic               rx_line,
  input  logic [MODEM_W-1:0] modem_n,
  input  logic               txf_wr,
  input  logic               tx_busy,
  input  logic               rx_busy,
  output logic               osc_en,
  output logic               asleep
);
  logic [DATA_W-1:0] fmt_q, ien_q, ext_q;
  logic sleep_ok, key_open, rx_start, modem_chg, wake_evt, idle_ok;

  doze_regs #(.DW(DATA_W), .KEY(KEY), .SBIT(SBIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .fmt_q(fmt_q), .ien_q(ien_q), .ext_q(ext_q),
    .sleep_ok(sleep_ok), .key_open(key_open)
  );

  doze_activity #(.MW(MODEM_W)) u_act (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .modem_n(modem_n),
    .txf_wr(txf_wr), .rx_start(rx_start), .modem_chg(modem_chg),
    .wake_evt(wake_evt)
  );

  doze_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_ok(sleep_ok), .irq_pend(irq_pend),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .wake_evt(wake_evt),
    .idle_ok(idle_ok), .asleep(asleep), .osc_en(osc_en)
  );
endmodule

// File: rtl/doze_chk.sv
module doze_chk #(
  parameter int unsigned SBIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [1:0] cfg_addr,
  input logic       key_open,
  input logic [7:0] fmt_q,
  input logic [7:0] ien_q,
  input logic [7:0] ext_q,
  input logic       irq_pend,
  input logic       tx_busy,
  input logic       rx_busy,
  input logic       wake_evt,
  input logic       osc_en,
  input logic       asleep
);
  a_r2_ext_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd2 && !key_open) |=> $stable(ext_q));

  a_r3_ien_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd1 && !ext_q[SBIT]) |=> $stable(ien_q[SBIT]));

  a_r4_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_q[SBIT] && ien_q[SBIT]) |=> !asleep);

  a_r4_entry_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(!irq_pend && !tx_busy && !rx_busy && !wake_evt));

  a_r5_irq_osc: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> osc_en);

  a_r5_irq_awake: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |=> !asleep);

  a_r6_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (osc_en ##1 !asleep));

  a_r11_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !cfg_wr) |=> ($stable(fmt_q) && $stable(ien_q) && $stable(ext_q)));
endmodule

bind uart_doze_ctrl doze_chk #(.SBIT(SBIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .key_open(key_open), .fmt_q(fmt_q), .ien_q(ien_q), .ext_q(ext_q),
  .irq_pend(irq_pend), .tx_busy(tx_busy), .rx_busy(rx_busy),
  .wake_evt(wake_evt), .osc_en(osc_en), .asleep(asleep)
);

// File: tb/sim_uart_doze_ctrl.sv
`timescale 1ns/100ps
module sim_uart_doze_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, irq_pend = 0, rx_line = 1, txf_wr = 0, tx_busy = 0, rx_busy = 0;
  logic [1:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [3:0] modem_n = 4'hF;
  logic osc_en, asleep;

  always #2 clk = ~clk;

  uart_doze_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_pend(irq_pend),
    .rx_line(rx_line), .modem_n(modem_n), .txf_wr(txf_wr), .tx_busy(tx_busy),
    .rx_busy(rx_busy), .osc_en(osc_en), .asleep(asleep)
  );

  typedef struct {
    string      tag;
    logic       e_osc;
    logic       e_slp;
    logic       chk_rd;
    logic [7:0] e_rd;
  } exp_t;

  exp_t q[$];
  int   errs = 0, checks = 0;
  bit   done = 0;

  // shadow inputs, applied at the falling edge by tick
  logic s_wr = 0, s_irq = 0, s_rx = 1, s_txf = 0, s_txb = 0, s_rxb = 0;
  logic [1:0] s_addr = 0;
  logic [7:0] s_wd = 0;
  logic [3:0] s_mod = 4'hF;

  task automatic tick(input string tag, input logic eo, input logic es,
                      input logic crd = 1'b0, input logic [7:0] erd = 8'h00);
    exp_t it;
    @(negedge clk);
    cfg_wr = s_wr; cfg_addr = s_addr; cfg_wdata = s_wd; irq_pend = s_irq;
    rx_line = s_rx; modem_n = s_mod; txf_wr = s_txf; tx_busy = s_txb; rx_busy = s_rxb;
    it.tag = tag; it.e_osc = eo; it.e_slp = es; it.chk_rd = crd; it.e_rd = erd;
    q.push_back(it);
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] e,
                    input logic eo, input logic es);
    s_addr = a;
    tick(tag, eo, es, 1'b1, e);
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [7:0] d,
                    input logic eo, input logic es);
    s_wr = 1; s_addr = a; s_wd = d;
    tick(tag, eo, es);
    s_wr = 0;
  endtask

  // monitor: compares one expected item per cycle, between the edges
  always @(negedge clk) begin
    exp_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (osc_en !== it.e_osc || asleep !== it.e_slp) begin
        errs++;
        $display("FAIL %s: osc_en/asleep got %b/%b expected %b/%b",
                 it.tag, osc_en, asleep, it.e_osc, it.e_slp);
      end
      if (it.chk_rd) begin
        checks++;
        if (cfg_rdata !== it.e_rd) begin
          errs++;
          $display("FAIL %s: rdata got %h expected %h", it.tag, cfg_rdata, it.e_rd);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd("R1", 2'd3, 8'h00, 1, 0);
    rd("R1", 2'd1, 8'h00, 1, 0);
    // R3 enable bit masked while extended bit is 0
    wr("R3", 2'd1, 8'h1F, 1, 0);
    rd("R3", 2'd1, 8'h0F, 1, 0);
    // R2 key gate
    wr("R2", 2'd2, 8'h10, 1, 0);
    wr("R2", 2'd3, 8'hBF, 1, 0);
    rd("R2", 2'd2, 8'h00, 1, 0);
    wr("R2", 2'd2, 8'h10, 1, 0);
    rd("R2", 2'd2, 8'h10, 1, 0);
    wr("R2", 2'd3, 8'h03, 1, 0);
    rd("R2", 2'd2, 8'h00, 1, 0);
    // R4 one enable alone is not enough
    tick("R4", 1, 0);
    tick("R4", 1, 0);
    wr("R3", 2'd1, 8'h1F, 1, 0);
    tick("R4", 1, 0);
    tick("R4", 0, 1);
    // R11 reads while asleep
    rd("R11", 2'd1, 8'h1F, 0, 1);
    rd("R11", 2'd3, 8'h03, 0, 1);
    // R6 start bit, held low line does not re-wake
    s_rx = 0;
    tick("R6", 1, 1);
    tick("R6", 1, 0);
    tick("R6", 0, 1);
    s_rx = 1;
    tick("R6", 0, 1);
    // R7 modem edge in both directions
    s_mod = 4'hB;
    tick("R7", 1, 1);
    tick("R7", 1, 0);
    tick("R7", 0, 1);
    s_mod = 4'hF;
    tick("R7", 1, 1);
    tick("R7", 1, 0);
    tick("R7", 0, 1);
    // R8 FIFO write then R9 drain
    s_txf = 1;
    tick("R8", 1, 1);
    s_txf = 0; s_txb = 1;
    tick("R9", 1, 0);
    tick("R9", 1, 0);
    tick("R9", 1, 0);
    s_txb = 0;
    tick("R9", 1, 0);
    tick("R9", 0, 1);
    s_rxb = 1;
    tick("R9", 0, 1);
    tick("R9", 1, 0);
    s_rxb = 0;
    tick("R9", 1, 0);
    tick("R9", 0, 1);
    // R5 pending interrupt
    s_irq = 1;
    tick("R5", 1, 1);
    tick("R5", 1, 0);
    tick("R5", 1, 0);
    s_irq = 0;
    tick("R5", 1, 0);
    tick("R5", 0, 1);
    // R10 clearing the enable ends sleep for good
    wr("R10", 2'd1, 8'h0F, 0, 1);
    tick("R10", 1, 1);
    tick("R10", 1, 0);
    tick("R10", 1, 0);
    s_rx = 0;
    tick("R10", 1, 0);
    s_rx = 1;
    tick("R10", 1, 0);
    rd("R10", 2'd1, 8'h0F, 1, 0);
    tick("R10", 1, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule